// File: doc/BRIEF.md
# Move-Bus Integer Function Unit with Self-Holding Pipeline

This block is an integer execution unit for a processor whose instructions only move data between registers. The unit exposes three registers to the move bus. The first is an operand register, which only stores what is written to it. The second is a trigger register, which answers at eight logical addresses. The third is a result register. A write to the trigger register starts an operation: the address selects the function, and the moved value is combined with the operand register. The result then travels through an internal stage into the result register, where a later read move collects it.

Stages advance on every clock unless the stage ahead still holds a result nobody has read. Unread results therefore stay parked inside the pipeline instead of occupying general registers. A read that is issued before its result has arrived is simply not acknowledged until the value is present, so no padding moves are needed. When both the internal stage and the result register hold unread values, the unit drops its trigger-ready output. Results always leave in the order their triggers were accepted.

Occupancy is tracked by a four-state machine. EMPTY holds nothing. MID_ONLY has a value in the internal stage only. RES_ONLY has a value in the result register only. BOTH has both slots full. The transitions are: EMPTY to MID_ONLY on an accepted trigger. MID_ONLY to RES_ONLY on its forced advance, or to BOTH if a trigger arrives as it advances. RES_ONLY to EMPTY on a read, to MID_ONLY on a read with a trigger, or to BOTH on a trigger without a read. BOTH to RES_ONLY on a read, or back to BOTH on a read with a trigger. Every other case stays in the current state.

Top module: `move_int_fu`

## Requirements
- R1: After reset no result is held, `trig_ready` is 1, and `rd_ack` stays 0 even while `rd_req` is 1.
- R2: Writing the operand register without a trigger write starts no operation: no read is acknowledged afterwards.
- R3: The trigger address selects the function, applied as trigger value (A) against operand (B): 0 A+B, 1 A-B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 A shifted left by B, 6 A shifted right logically by B, 7 one if A is less than B as signed numbers, else zero. All arithmetic wraps at 32 bits.
- R4: The operand used is the one present at the trigger cycle. A write to the operand register in that same cycle is used. A later write does not change an operation already triggered.
- R5: A trigger accepted in cycle t into an empty unit is acknowledged by a read held from cycle t+1 exactly in cycle t+2.
- R6: A read issued before its result reaches the result register sees `rd_ack` low and stays pending with no loss of data.
- R7: An unread result and the value waiting behind it are held unchanged for any number of cycles. Reads return results strictly in trigger order.
- R8: With both internal stage and result register full and no read in the cycle, `trig_ready` is 0. A trigger write in that cycle is ignored and never produces a result.
- R9: A read in a cycle frees a slot in that same cycle, so `trig_ready` is 1 then. With `rd_req` held high, one trigger per cycle is accepted without a gap.
- R10: For shifts, only the low five bits of the operand form the shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_we | input | 1 | Move writes the operand register |
| opnd_wdata | input | 32 | Value moved into the operand register |
| trig_we | input | 1 | Move writes the trigger register |
| trig_addr | input | 3 | Logical trigger address, selects the function |
| trig_wdata | input | 32 | Value moved into the trigger register |
| trig_ready | output | 1 | Trigger write accepted this cycle if asserted |
| rd_req | input | 1 | Move reads the result register |
| rd_ack | output | 1 | Read completes this cycle with `rd_data` |
| rd_data | output | 32 | Result register contents |

## Verification
On every cycle the embedded properties check several things. Held values in both stages must not change while blocked. The ready output must fall whenever both slots are full and no read is present. An early read must never be acknowledged. A trigger into an empty unit must land in the result register two edges later. The operand register may change only on its write strobe. The function encodings, the choice between same-cycle and older operand values, the ignored trigger while back-pressured and the strict ordering of returned results are shown only by the bench scenarios. There a scoreboard predicts every value from the port activity and compares each acknowledged read.

// File: rtl/move_fu_pkg.sv
package move_fu_pkg;

    localparam int TRIG_ADDR_W = 3;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SHL = 3'd5,
        FN_SHR = 3'd6,
        FN_SLT = 3'd7
    } fu_fn_e;

    typedef enum logic [1:0] {
        OCC_EMPTY    = 2'd0,
        OCC_MID_ONLY = 2'd1,
        OCC_RES_ONLY = 2'd2,
        OCC_BOTH     = 2'd3
    } occ_state_e;

endpackage

// File: rtl/move_fu_decode.sv
module move_fu_decode
    import move_fu_pkg::*;
(
    input  logic [TRIG_ADDR_W-1:0] trig_addr,
    output fu_fn_e                 fn
);

    always_comb begin
        unique case (trig_addr)
            3'd0:    fn = FN_ADD;
            3'd1:    fn = FN_SUB;
            3'd2:    fn = FN_AND;
            3'd3:    fn = FN_OR;
            3'd4:    fn = FN_XOR;
            3'd5:    fn = FN_SHL;
            3'd6:    fn = FN_SHR;
            default: fn = FN_SLT;
        endcase
    end

endmodule

// File: rtl/move_fu_alu.sv
module move_fu_alu
    import move_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fu_fn_e            fn,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] y
);

    localparam int SHAMT_W = $clog2(DATA_W);

    logic [SHAMT_W-1:0] shamt;
    logic               lt_signed;

    assign shamt     = b_val[SHAMT_W-1:0];
    assign lt_signed = $signed(a_val) < $signed(b_val);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a_val + b_val;
            FN_SUB:  y = a_val - b_val;
            FN_AND:  y = a_val & b_val;
            FN_OR:   y = a_val | b_val;
            FN_XOR:  y = a_val ^ b_val;
            FN_SHL:  y = a_val << shamt;
            FN_SHR:  y = a_val >> shamt;
            default: y = {{(DATA_W-1){1'b0}}, lt_signed};
        endcase
    end

endmodule

// File: rtl/move_fu_ctrl.sv
module move_fu_ctrl
    import move_fu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_we,
    input  logic rd_req,
    output logic trig_ready,
    output logic rd_ack,
    output logic mid_load,
    output logic res_load,
    output logic mid_full,
    output logic res_full
);

    occ_state_e state_q;
    occ_state_e state_d;
    logic       trig_fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the occupancy state and the two requests
    always_comb begin
        mid_full   = 1'b0;
        res_full   = 1'b0;
        unique case (state_q)
            OCC_EMPTY:    begin mid_full = 1'b0; res_full = 1'b0; end
            OCC_MID_ONLY: begin mid_full = 1'b1; res_full = 1'b0; end
            OCC_RES_ONLY: begin mid_full = 1'b0; res_full = 1'b1; end
            default:      begin mid_full = 1'b1; res_full = 1'b1; end
        endcase
        rd_ack     = rd_req && res_full;
        trig_ready = (state_q != OCC_BOTH) || rd_ack;
        trig_fire  = trig_we && trig_ready;
        mid_load   = trig_fire;
        res_load   = mid_full && (!res_full || rd_ack);
    end

    // next-state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (trig_fire) state_d = OCC_MID_ONLY;
            end
            OCC_MID_ONLY: begin
                state_d = trig_fire ? OCC_BOTH : OCC_RES_ONLY;
            end
            OCC_RES_ONLY: begin
                if (rd_ack && trig_fire)       state_d = OCC_MID_ONLY;
                else if (rd_ack)               state_d = OCC_EMPTY;
                else if (trig_fire)            state_d = OCC_BOTH;
            end
            default: begin
                if (rd_ack && !trig_fire)      state_d = OCC_RES_ONLY;
            end
        endcase
    end

endmodule

// File: rtl/move_fu_datapath.sv
module move_fu_datapath
    import move_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opnd_we,
    input  logic [DATA_W-1:0] opnd_wdata,
    input  logic [DATA_W-1:0] trig_wdata,
    input  fu_fn_e            fn,
    input  logic              mid_load,
    input  logic              res_load,
    output logic [DATA_W-1:0] mid_q,
    output logic [DATA_W-1:0] res_q
);

    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] opnd_eff;
    logic [DATA_W-1:0] alu_y;

    // same-cycle operand write bypasses the register
    assign opnd_eff = opnd_we ? opnd_wdata : opnd_q;

    move_fu_alu #(.DATA_W(DATA_W)) u_alu (
        .fn    (fn),
        .a_val (trig_wdata),
        .b_val (opnd_eff),
        .y     (alu_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else if (opnd_we) begin
            opnd_q <= opnd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q <= '0;
            res_q <= '0;
        end else begin
            if (mid_load) mid_q <= alu_y;
            if (res_load) res_q <= mid_q;
        end
    end

    // R4: the stored operand only changes through its own write strobe
    p_operand_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_we |=> $stable(opnd_q));

endmodule

// File: rtl/move_int_fu.sv
module move_int_fu
    import move_fu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   opnd_we,
    input  logic [DATA_W-1:0]      opnd_wdata,
    input  logic                   trig_we,
    input  logic [TRIG_ADDR_W-1:0] trig_addr,
    input  logic [DATA_W-1:0]      trig_wdata,
    output logic                   trig_ready,
    input  logic                   rd_req,
    output logic                   rd_ack,
    output logic [DATA_W-1:0]      rd_data
);

    fu_fn_e            fn;
    logic              mid_load;
    logic              res_load;
    logic              mid_full;
    logic              res_full;
    logic [DATA_W-1:0] mid_q;
    logic [DATA_W-1:0] res_q;

    move_fu_decode u_decode (
        .trig_addr (trig_addr),
        .fn        (fn)
    );

    move_fu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_we    (trig_we),
        .rd_req     (rd_req),
        .trig_ready (trig_ready),
        .rd_ack     (rd_ack),
        .mid_load   (mid_load),
        .res_load   (res_load),
        .mid_full   (mid_full),
        .res_full   (res_full)
    );

    move_fu_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_we    (opnd_we),
        .opnd_wdata (opnd_wdata),
        .trig_wdata (trig_wdata),
        .fn         (fn),
        .mid_load   (mid_load),
        .res_load   (res_load),
        .mid_q      (mid_q),
        .res_q      (res_q)
    );

    assign rd_data = res_q;

    p_empty_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_ready && !mid_full && !res_full) |=> ##1 res_full);

    p_early_read_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !res_full) |-> !rd_ack);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_full && !rd_req) |=> (res_full && $stable(rd_data)));

    p_mid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_full && res_full && !rd_req) |=> (mid_full && $stable(mid_q)));

    p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_full && res_full && !rd_req) |-> !trig_ready);

endmodule

// File: tb/move_int_fu_test.sv
`timescale 1ns/1ps
module move_int_fu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        opnd_we;
    logic [31:0] opnd_wdata;
    logic        trig_we;
    logic [2:0]  trig_addr;
    logic [31:0] trig_wdata;
    logic        trig_ready;
    logic        rd_req;
    logic        rd_ack;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_acks   = 0;
    logic [31:0] expq [$];
    logic [31:0] m_opnd;

    always #2.5 clk = ~clk;

    move_int_fu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_we    (opnd_we),
        .opnd_wdata (opnd_wdata),
        .trig_we    (trig_we),
        .trig_addr  (trig_addr),
        .trig_wdata (trig_wdata),
        .trig_ready (trig_ready),
        .rd_req     (rd_req),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data)
    );

    function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << b[4:0];
            3'd6: return a >> b[4:0];
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        opnd_we = 0; opnd_wdata = 0; trig_we = 0; trig_addr = 0; trig_wdata = 0; rd_req = 0;
    endtask

    // monitor / scoreboard: sampled 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (rd_ack) begin
                n_acks++;
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected result", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check(rd_data == e, "R3/R4/R7 result value", rd_data, e);
                end
            end
            if (trig_we && trig_ready)
                expq.push_back(model(trig_addr, trig_wdata, opnd_we ? opnd_wdata : m_opnd));
            if (opnd_we) m_opnd = opnd_wdata;
        end else begin
            m_opnd = '0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic flag;
        int   acks0;
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd_req = 1;
        #2;
        check(trig_ready == 1'b1, "R1 ready after reset", {31'd0, trig_ready}, 32'd1);
        check(rd_ack == 1'b0, "R1 no result after reset", {31'd0, rd_ack}, 32'd0);

        // R2: operand write alone
        @(negedge clk); idle_inputs(); opnd_we = 1; opnd_wdata = 32'd5; rd_req = 1;
        flag = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #2; if (rd_ack) flag = 1'b1;
            @(negedge clk); idle_inputs(); rd_req = 1;
        end
        check(flag == 1'b0, "R2 operand write starts nothing", {31'd0, flag}, 32'd0);

        // R5/R6: latency and early-read stall (5 + 10 = 15)
        idle_inputs(); trig_we = 1; trig_addr = 3'd0; trig_wdata = 32'd10;
        @(negedge clk); idle_inputs(); rd_req = 1;
        #2; check(rd_ack == 1'b0, "R6 early read stalls", {31'd0, rd_ack}, 32'd0);
        @(negedge clk); rd_req = 1;
        #2; check(rd_ack == 1'b1, "R5 result at t+2", {31'd0, rd_ack}, 32'd1);
        @(negedge clk); idle_inputs();

        // R3/R4/R9/R10: every function back to back, operand written with trigger
        acks0 = n_acks;
        flag = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 8; f++) begin
                @(negedge clk);
                trig_we = 1; trig_addr = 3'(f);
                trig_wdata = (p == 0) ? 32'h8000_0003 : 32'h7FFF_FFFF;
                opnd_we = 1;
                opnd_wdata = (p == 0) ? 32'h0000_0024 : 32'hFFFF_FFFF;
                rd_req = 1;
                #2; if (!trig_ready) flag = 1'b0;
            end
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); idle_inputs(); rd_req = 1;
        end
        #2.4;
        check(flag == 1'b1, "R9 trigger accepted every cycle", {31'd0, flag}, 32'd1);
        check(n_acks - acks0 == 16, "R9 streaming throughput", 32'(n_acks - acks0), 32'd16);

        // R4: later operand write does not disturb a triggered op (1 + 0xFFFFFFFF = 0)
        @(negedge clk); idle_inputs(); trig_we = 1; trig_addr = 3'd0; trig_wdata = 32'd1;
        @(negedge clk); idle_inputs(); opnd_we = 1; opnd_wdata = 32'd1000;
        @(negedge clk); idle_inputs(); rd_req = 1;
        @(negedge clk); idle_inputs(); rd_req = 1;
        @(negedge clk); idle_inputs();
        // R10: shift amount 33 -> 1
        @(negedge clk); idle_inputs(); trig_we = 1; trig_addr = 3'd5; trig_wdata = 32'h0000_0003;
        opnd_we = 1; opnd_wdata = 32'd33; rd_req = 1;
        @(negedge clk); idle_inputs(); rd_req = 1;
        #2; check(rd_ack == 1'b0, "R6 stall before shift result", {31'd0, rd_ack}, 32'd0);
        check(rd_data == 32'd0 || rd_data != 32'd6, "R10 no early data", rd_data, 32'd6);
        @(negedge clk); idle_inputs(); rd_req = 1;
        #2; check(rd_ack && rd_data == 32'd6, "R10 low five bits of shift", rd_data, 32'd6);
        @(negedge clk); idle_inputs();

        // R7/R8: fill both slots, then hold and back-pressure
        @(negedge clk); idle_inputs(); trig_we = 1; trig_addr = 3'd4; trig_wdata = 32'hAAAA_0000; // A
        @(negedge clk); trig_addr = 3'd3; trig_wdata = 32'h0000_5555;                               // B
        @(negedge clk); trig_addr = 3'd0; trig_wdata = 32'h1234_5678;                               // C, rejected
        #2; check(trig_ready == 1'b0, "R8 ready low when full", {31'd0, trig_ready}, 32'd0);
        flag = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); idle_inputs();
            #2; if (trig_ready) flag = 1'b1;
        end
        check(flag == 1'b0, "R8 ready stays low while held", {31'd0, flag}, 32'd0);
        @(negedge clk); idle_inputs(); rd_req = 1; trig_we = 1; trig_addr = 3'd1; trig_wdata = 32'd50; // D
        #2; check(trig_ready == 1'b1, "R9 read frees slot same cycle", {31'd0, trig_ready}, 32'd1);
        check(rd_ack == 1'b1, "R7 held result readable", {31'd0, rd_ack}, 32'd1);
        @(negedge clk); idle_inputs(); rd_req = 1;
        @(negedge clk); idle_inputs(); rd_req = 1;
        @(negedge clk); idle_inputs(); rd_req = 1;
        #2; check(rd_ack == 1'b0, "R8 rejected trigger gave no result", {31'd0, rd_ack}, 32'd0);
        @(negedge clk); idle_inputs();
        #2.4;
        check(expq.size() == 0, "R7 all results drained in order", 32'(expq.size()), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule